// File: doc/BRIEF.md
# Double-Buffered Serial Receiver

This block is the receive data path of an asynchronous serial port. A hidden shift register assembles each incoming character from the serial line, least significant bit first. Once the last data bit has been taken, the character is copied into a holding register without any help from the CPU. The shift register is then free for the next character while software is still fetching the previous one.

Bit timing comes from a programmable prescaler that produces sixteen oversample ticks per bit. A falling edge on the idle line is accepted as a start bit only if the line is still low at the middle of that bit. Each data bit is then taken once, at its own centre. The CPU sees only the holding register and a ready flag. Reading the register clears the flag, and writes have no effect. A standby input clears the holding register and parks the receiver.

Top module: `serial_rx_dbuf`

## Requirements
- R1: During and after reset, `rd_data` is 0x00, and `byte_rdy` and `frame_err` are 0.
- R2: A frame is a low start bit, 8 data bits and a high stop bit. The first data bit on the line lands in `rd_data[0]` and the last in `rd_data[7]`.
- R3: Each accepted frame is copied into `rd_data` and sets `byte_rdy`, with no bus action. This happens no later than the end of the stop bit, and `byte_rdy` never rises without such a copy.
- R4: One oversample tick occurs every `baud_div`+1 clocks, and one bit lasts 16 ticks. Reception is correct with `baud_div` at 0 and at 3.
- R5: A low pulse that ends before the middle of the start bit (8 ticks) is not treated as a frame. No byte results, and the next valid frame is received normally.
- R6: A frame that follows the previous stop bit with no idle time is received. While it is being shifted in, the previous byte stays readable in `rd_data`.
- R7: A read (`bus_en`=1, `bus_we`=0) clears `byte_rdy` in the following cycle unless a new byte arrives in the same cycle. The read leaves `rd_data` unchanged.
- R8: A write (`bus_en`=1, `bus_we`=1) changes neither `rd_data` nor `byte_rdy`.
- R9: In the cycle after `standby` goes high, `rd_data` is 0x00 and `byte_rdy` is 0. While `standby` stays high, line activity produces no byte. Reception works again after `standby` falls.
- R10: A stop bit sampled low still copies the byte and sets `byte_rdy`. It also pulses `frame_err` high for exactly one cycle, in the same cycle as the copy. The receiver then waits for the line to return high before it looks for a new start bit. A good stop bit gives no pulse.
- R11: An unread byte is overwritten by the next received byte, and `byte_rdy` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Prescaler divisor: oversample tick period minus one |
| rxd | input | 1 | Serial receive line, idle high |
| standby | input | 1 | Standby request, clears and parks the receiver |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus access is a write (ignored) when 1 |
| rd_data | output | DATA_W | Receive holding register |
| byte_rdy | output | 1 | A byte is waiting in the holding register |
| frame_err | output | 1 | One-cycle pulse: the stop bit was sampled low |

## Verification
The serial line passes through two synchronizer flops. A start edge is picked up at the next tick, so the copy into the holding register happens at the middle of the stop bit. That is roughly nine and a half bit times after the falling edge, plus up to `baud_div`+3 clocks. The bench therefore checks received bytes at the end of the stop bit, which leaves half a bit of margin either way. Bus reads, bus writes and standby act through one register stage, so their results are sampled at the falling clock edge one cycle after the strobe. The framing strobe lasts only one cycle, so a monitor at every falling edge counts the pulses and checks that `byte_rdy` is already high when each one appears.

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rxd,
  input  logic              standby,
  input  logic              bus_en,
  input  logic              bus_we,
  output logic [DATA_W-1:0] rd_data,
  output logic              byte_rdy,
  output logic              frame_err
);
  localparam int OS_W = $clog2(OSR);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OSR / 2 - 1);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OSR - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_HOLD} rx_st_t;

  rx_st_t            state;
  logic [1:0]        rx_sync;
  logic              rx_s;
  logic [DIV_W-1:0]  pre_cnt;
  logic              tick;
  logic [OS_W-1:0]   os_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              xfer;
  logic              host_rd;

  assign rx_s    = rx_sync[1];
  assign tick    = (pre_cnt >= baud_div);
  assign xfer    = tick && (state == ST_STOP) && (os_cnt == OS_LAST);
  assign host_rd = bus_en && !bus_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_cnt <= '0;
    else if (standby) pre_cnt <= '0;
    else if (tick)    pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (standby) begin
      state   <= ST_IDLE;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE:
          if (!rx_s) begin
            state  <= ST_START;
            os_cnt <= '0;
          end
        ST_START:
          if (os_cnt == OS_MID) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= rx_s ? ST_IDLE : ST_DATA;
          end else begin
            os_cnt <= os_cnt + OS_W'(1);
          end
        ST_DATA:
          if (os_cnt == OS_LAST) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[DATA_W-1:1]};
            if (bit_cnt == BC_LAST) state <= ST_STOP;
            else                    bit_cnt <= bit_cnt + BC_W'(1);
          end else begin
            os_cnt <= os_cnt + OS_W'(1);
          end
        ST_STOP:
          if (os_cnt == OS_LAST) begin
            os_cnt <= '0;
            state  <= rx_s ? ST_IDLE : ST_HOLD;
          end else begin
            os_cnt <= os_cnt + OS_W'(1);
          end
        ST_HOLD:
          if (rx_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      byte_rdy  <= 1'b0;
      frame_err <= 1'b0;
    end else if (standby) begin
      rd_data   <= '0;
      byte_rdy  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= xfer && !rx_s;
      if (xfer) begin
        rd_data  <= shreg;
        byte_rdy <= 1'b1;
      end else if (host_rd) begin
        byte_rdy <= 1'b0;
      end
    end
  end
endmodule

module serial_rx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              bus_en,
  input logic              bus_we,
  input logic [DATA_W-1:0] rd_data,
  input logic              byte_rdy,
  input logic              frame_err,
  input logic              xfer
);
  assert_standby_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (rd_data == '0 && !byte_rdy && !frame_err));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !xfer) |=> !byte_rdy);

  assert_data_only_on_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_data) && !$past(standby)) |-> $past(xfer));

  assert_ready_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_rdy) |-> $past(xfer));

  assert_ferr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_ferr_with_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (byte_rdy && $past(xfer)));
endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .bus_en(bus_en), .bus_we(bus_we),
  .rd_data(rd_data), .byte_rdy(byte_rdy), .frame_err(frame_err), .xfer(xfer)
);

// File: tb/serial_rx_dbuf_tb.sv
module serial_rx_dbuf_tb;
  localparam int DW = 8;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] baud_div = DIV_W'(3);
  logic             rxd = 1'b1;
  logic             standby = 1'b0;
  logic             bus_en = 1'b0;
  logic             bus_we = 1'b0;
  logic [DW-1:0]    rd_data;
  logic             byte_rdy;
  logic             frame_err;

  int errors = 0;
  int checks = 0;
  int cur_div = 3;
  int ferr_seen = 0;
  int ferr_bad = 0;
  bit done = 1'b0;

  serial_rx_dbuf #(.DATA_W(DW), .OSR(16), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rxd(rxd), .standby(standby),
    .bus_en(bus_en), .bus_we(bus_we), .rd_data(rd_data), .byte_rdy(byte_rdy),
    .frame_err(frame_err)
  );

  always @(negedge clk)
    if (frame_err) begin
      ferr_seen++;
      if (!byte_rdy) ferr_bad++;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input bit v);
    rxd = v;
    wait_cyc(16 * (cur_div + 1));
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop);
    rxd = 1'b1;
  endtask

  task automatic bus_read(output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0;
    d = rd_data;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic bus_write();
    bus_en = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(rd_data == 8'h00, "R1 data", int'(rd_data), 0);
    chk(byte_rdy == 1'b0, "R1 ready", int'(byte_rdy), 0);
    chk(frame_err == 1'b0, "R1 ferr", int'(frame_err), 0);
  endtask

  task automatic t_basic(input int div, input logic [7:0] b);
    logic [7:0] d;
    int f0;
    cur_div = div;
    baud_div = DIV_W'(div);
    wait_cyc(32 * (div + 1));
    f0 = ferr_seen;
    chk(byte_rdy == 1'b0, "R3 idle", int'(byte_rdy), 0);
    send_frame(b, 1'b1);
    chk(byte_rdy == 1'b1, "R3 R4 ready", int'(byte_rdy), 1);
    chk(rd_data == b, "R2 R4 data", int'(rd_data), int'(b));
    chk(ferr_seen == f0, "R10 no ferr on good stop", ferr_seen - f0, 0);
    bus_read(d);
    chk(d == b, "R7 read value", int'(d), int'(b));
    chk(byte_rdy == 1'b0, "R7 cleared", int'(byte_rdy), 0);
    chk(rd_data == b, "R7 data kept", int'(rd_data), int'(b));
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    wait_cyc(4 * (cur_div + 1));
    rxd = 1'b1;
    wait_cyc(12 * 16 * (cur_div + 1));
    chk(byte_rdy == 1'b0, "R5 glitch ignored", int'(byte_rdy), 0);
    send_frame(8'h5A, 1'b1);
    chk(byte_rdy == 1'b1 && rd_data == 8'h5A, "R5 frame after glitch", int'(rd_data), 'h5A);
  endtask

  task automatic t_b2b();
    logic [7:0] d;
    logic [7:0] nb = 8'h6B;
    bus_read(d);
    send_frame(8'h96, 1'b1);
    drive_bit(1'b0);
    drive_bit(nb[0]);
    bus_read(d);
    chk(d == 8'h96, "R6 first byte readable", int'(d), 'h96);
    chk(byte_rdy == 1'b0, "R6 R7 flag cleared mid frame", int'(byte_rdy), 0);
    for (int i = 1; i < 8; i++) drive_bit(nb[i]);
    drive_bit(1'b1);
    chk(rd_data == nb, "R6 second byte", int'(rd_data), int'(nb));
    chk(byte_rdy == 1'b1, "R6 second ready", int'(byte_rdy), 1);
  endtask

  task automatic t_overwrite();
    send_frame(8'hE7, 1'b1);
    chk(rd_data == 8'hE7, "R11 overwritten", int'(rd_data), 'hE7);
    chk(byte_rdy == 1'b1, "R11 ready held", int'(byte_rdy), 1);
  endtask

  task automatic t_write();
    bus_write();
    chk(rd_data == 8'hE7, "R8 data after write", int'(rd_data), 'hE7);
    chk(byte_rdy == 1'b1, "R8 ready after write", int'(byte_rdy), 1);
  endtask

  task automatic t_standby();
    standby = 1'b1;
    wait_cyc(1);
    chk(rd_data == 8'h00, "R9 data cleared", int'(rd_data), 0);
    chk(byte_rdy == 1'b0, "R9 ready cleared", int'(byte_rdy), 0);
    send_frame(8'h77, 1'b1);
    chk(byte_rdy == 1'b0 && rd_data == 8'h00, "R9 line ignored", int'(rd_data), 0);
    standby = 1'b0;
    wait_cyc(32 * (cur_div + 1));
    chk(byte_rdy == 1'b0, "R9 nothing after release", int'(byte_rdy), 0);
    send_frame(8'h4B, 1'b1);
    chk(rd_data == 8'h4B && byte_rdy, "R9 resumes", int'(rd_data), 'h4B);
  endtask

  task automatic t_ferr();
    logic [7:0] d;
    int f0;
    bus_read(d);
    f0 = ferr_seen;
    send_frame(8'hD4, 1'b0);
    wait_cyc(2 * 16 * (cur_div + 1));
    chk(rd_data == 8'hD4, "R10 byte kept", int'(rd_data), 'hD4);
    chk(byte_rdy == 1'b1, "R10 ready set", int'(byte_rdy), 1);
    chk(ferr_seen - f0 == 1, "R10 one strobe", ferr_seen - f0, 1);
    chk(ferr_bad == 0, "R10 strobe with copy", ferr_bad, 0);
    bus_read(d);
    send_frame(8'h2E, 1'b1);
    chk(rd_data == 8'h2E && byte_rdy, "R10 recovers", int'(rd_data), 'h2E);
    chk(ferr_seen - f0 == 1, "R10 no extra strobe", ferr_seen - f0, 1);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_basic(3, 8'h1D);
    t_basic(0, 8'hC2);
    t_basic(3, 8'h80);
    t_glitch();
    t_b2b();
    t_overwrite();
    t_write();
    t_standby();
    t_ferr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule